// File: doc/BRIEF.md
# Control Register Bank with Set/Clear Aliases

This block holds the two control words of a display controller and gives software three ways to change each of them. A plain write replaces the whole word. A set-alias write ORs its data into the word. A clear-alias write removes the bits that are one in its data. This lets a driver change one bit without a read-modify-write race. A fourth alias address per word is reserved. Reads return the word one cycle after the address is presented, through a registered read port.

The first word carries the controller's life-cycle bits:
- a soft-reset bit and a clock-gate bit, each of which finishes its release on its own after a fixed number of cycles, so software polls for it to read zero;
- a run bit;
- a dot-clock mode bit;
- a free configuration field.

When the mode bit is dropped while the controller runs, the run bit stays set until the downstream FIFO reports empty, and only then clears itself.

The second word carries:
- a FIFO-flush control;
- a format field;
- an interrupt enable and an interrupt status bit. The status bit is set by a frame-done pulse, and the bits survive set/clear updates of the format field.

While soft reset reads one, every other field is held at its reset value.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset the first word (word address 0) reads 0xC000_0000, the second word (word address 4) reads 0, soft_rst_o and clk_gate_o are 1, and run_o, fifo_flush_o and irq_o are 0.
- R2: Address bit 2 selects the word (0 first, 1 second). Address bits 1:0 select the access: 0 is a plain full write, 1 the set alias, 2 the clear alias, 3 a write that changes nothing. A read of any alias returns the selected word on rdata one cycle after the address.
- R3: A set-alias write only turns bits on, and a clear-alias write only turns off the bits that are one in its data. All other bits keep their value.
- R4: Clearing bit 31 (soft reset) while it is one starts a release of RST_CYCLES cycles. The bit and soft_rst_o read 1 until RST_CYCLES clock edges after the write edge, then 0.
- R5: Any write that leaves bit 31 at one sets bit 31 and bit 30 (clock gate) at once, and returns every other field of both words to its reset value.
- R6: While bit 31 reads 1, writes to the other fields of either word are ignored, and bit 30 cannot be released.
- R7: Clearing bit 30 while soft reset reads 0 starts a release of GATE_CYCLES cycles, after which bit 30 and clk_gate_o read 0.
- R8: Bit 0 of the first word is run and bit 1 is dot-clock mode. While run is 1 and mode is 0, run stays 1 until fifo_empty_i is high at a clock edge, and it clears at that edge.
- R9: Bit 0 of the second word drives fifo_flush_o for as long as it is set.
- R10: A frame_done_i pulse sets bit 9 (interrupt status) of the second word. When a software clear comes in the same cycle, the pulse wins. irq_o is the AND of bit 8 (interrupt enable) and bit 9.
- R11: Set-alias and clear-alias writes to the format field (bits 7:4 of the second word) leave bits 8 and 9 unchanged.
- R12: The configuration field, bits 9:2 of the first word, reads back exactly what the aliases made of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Word select (bit 2) and access alias (bits 1:0) |
| wdata | input | 32 | Write data or bit mask |
| we | input | 1 | Write strobe |
| fifo_empty_i | input | 1 | Downstream FIFO has drained |
| frame_done_i | input | 1 | Frame-done pulse |
| rdata | output | 32 | Registered read data |
| soft_rst_o | output | 1 | Soft reset to the controller |
| clk_gate_o | output | 1 | Clock gate to the controller |
| run_o | output | 1 | Controller run |
| fifo_flush_o | output | 1 | Hold the pixel FIFO flushed |
| irq_o | output | 1 | Frame interrupt |

## Verification
The properties assume that fifo_empty_i and frame_done_i are synchronous to clk. They also assume that software may override run in any cycle in which it writes the first word, so the drain property excludes those cycles. The stimulus changes every input only at the falling edge and issues at most one write per cycle. It keeps the run, mode and lifecycle bits out of the alias sweeps, so the sweep results depend only on the alias arithmetic. The drain case holds fifo_empty_i low across several cycles before raising it, so a premature stop would be seen.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    AL_PLAIN = 2'd0,
    AL_SET   = 2'd1,
    AL_CLR   = 2'd2,
    AL_NONE  = 2'd3
  } alias_e;

  localparam int B_SRST  = 31;
  localparam int B_GATE  = 30;
  localparam int B_RUN   = 0;
  localparam int B_MODE  = 1;
  localparam int B_FLUSH = 0;
  localparam int FMT_LO  = 4;
  localparam int CFG_LO  = 2;
endpackage

// File: rtl/ctlreg_merge.sv
module ctlreg_merge
  import ctlreg_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] wd,
  input  alias_e       al,
  output logic [W-1:0] nxt
);
  for (genvar gi = 0; gi < W; gi++) begin : g_bit
    assign nxt[gi] = (al == AL_PLAIN) ? wd[gi] :
                     (al == AL_SET)   ? (cur[gi] | wd[gi]) :
                     (al == AL_CLR)   ? (cur[gi] & ~wd[gi]) :
                                        cur[gi];
  end
endmodule

// File: rtl/ctlreg_hs.sv
module ctlreg_hs #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic bit_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          bit_q;

  always_ff @(posedge clk) begin
    if (rst || set_i) begin
      bit_q  <= 1'b1;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        bit_q  <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else if (clr_i && bit_q) begin
      pend_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int FMT_W       = 4,
  parameter int RST_CYCLES  = 4,
  parameter int GATE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              fifo_empty_i,
  input  logic              frame_done_i,
  output logic [DATA_W-1:0] rdata,
  output logic              soft_rst_o,
  output logic              clk_gate_o,
  output logic              run_o,
  output logic              fifo_flush_o,
  output logic              irq_o
);
  localparam int CFG_HI = CFG_LO + CFG_W - 1;
  localparam int FMT_HI = FMT_LO + FMT_W - 1;
  localparam int IEN_B  = FMT_HI + 1;
  localparam int IST_B  = FMT_HI + 2;

  logic             run_q, mode_q, flush_q, ien_q, ist_q;
  logic [CFG_W-1:0] cfg_q;
  logic [FMT_W-1:0] fmt_q;
  logic [DATA_W-1:0] rdata_q;
  logic             sr_q, cg_q;

  logic [DATA_W-1:0] view_c, view_1, nv_c, nv_1;
  alias_e al;
  logic   sel1, wr_c, wr_1;
  logic   sr_set, sr_clr, cg_set, cg_clr, hold;

  always_comb begin
    view_c          = '0;
    view_c[B_SRST]  = sr_q;
    view_c[B_GATE]  = cg_q;
    view_c[CFG_HI:CFG_LO] = cfg_q;
    view_c[B_MODE]  = mode_q;
    view_c[B_RUN]   = run_q;
    view_1          = '0;
    view_1[B_FLUSH] = flush_q;
    view_1[FMT_HI:FMT_LO] = fmt_q;
    view_1[IEN_B]   = ien_q;
    view_1[IST_B]   = ist_q;
  end

  assign al   = alias_e'(addr[1:0]);
  assign sel1 = addr[2];
  assign wr_c = we && !sel1 && (al != AL_NONE);
  assign wr_1 = we &&  sel1 && (al != AL_NONE);

  ctlreg_merge #(.W(DATA_W)) u_merge_c (.cur(view_c), .wd(wdata), .al(al), .nxt(nv_c));
  ctlreg_merge #(.W(DATA_W)) u_merge_1 (.cur(view_1), .wd(wdata), .al(al), .nxt(nv_1));

  assign sr_set = wr_c &&  nv_c[B_SRST];
  assign sr_clr = wr_c && !nv_c[B_SRST];
  assign cg_set = sr_set || (wr_c && !sr_q && nv_c[B_GATE]);
  assign cg_clr = wr_c && !sr_q && !nv_c[B_GATE];
  assign hold   = sr_q || sr_set;

  ctlreg_hs #(.CYCLES(RST_CYCLES)) u_hs_srst (
    .clk(clk), .rst(rst), .set_i(sr_set), .clr_i(sr_clr), .bit_o(sr_q));
  ctlreg_hs #(.CYCLES(GATE_CYCLES)) u_hs_gate (
    .clk(clk), .rst(rst), .set_i(cg_set), .clr_i(cg_clr), .bit_o(cg_q));

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      run_q   <= 1'b0;
      mode_q  <= 1'b0;
      cfg_q   <= '0;
      flush_q <= 1'b0;
      fmt_q   <= '0;
      ien_q   <= 1'b0;
      ist_q   <= 1'b0;
    end else begin
      if (wr_c) begin
        mode_q <= nv_c[B_MODE];
        cfg_q  <= nv_c[CFG_HI:CFG_LO];
      end
      if (run_q && !mode_q && fifo_empty_i) run_q <= 1'b0;
      else if (wr_c)                        run_q <= nv_c[B_RUN];
      if (wr_1) begin
        flush_q <= nv_1[B_FLUSH];
        fmt_q   <= nv_1[FMT_HI:FMT_LO];
        ien_q   <= nv_1[IEN_B];
      end
      if (frame_done_i) ist_q <= 1'b1;
      else if (wr_1)    ist_q <= nv_1[IST_B];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= sel1 ? view_1 : view_c;
  end

  logic unused_bits;
  assign unused_bits = ^{nv_c[B_GATE-1:CFG_HI+1], nv_1[DATA_W-1:IST_B+1],
                         nv_1[FMT_LO-1:B_FLUSH+1]};

  assign rdata        = rdata_q;
  assign soft_rst_o   = sr_q;
  assign clk_gate_o   = cg_q;
  assign run_o        = run_q;
  assign fifo_flush_o = flush_q;
  assign irq_o        = ien_q & ist_q;
endmodule

// File: rtl/ctlreg_bank_chk.sv
module ctlreg_bank_chk
  import ctlreg_pkg::*;
#(
  parameter int IEN_B = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              we,
  input logic              fifo_empty_i,
  input logic              frame_done_i,
  input logic              soft_rst_o,
  input logic              clk_gate_o,
  input logic              run_o,
  input logic              mode,
  input logic              ien,
  input logic              ist
);
  logic ctrl_wr;
  assign ctrl_wr = we && !addr[2];

  // R6
  srst_blocks_run_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |-> !run_o);

  // R5
  srst_forces_gate_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |-> clk_gate_o);

  // R7
  gate_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_gate_o) |-> !soft_rst_o);

  // R8
  drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_o && !mode && !fifo_empty_i && !ctrl_wr) |=> run_o);

  // R8
  drain_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (run_o && !mode && fifo_empty_i) |=> !run_o);

  // R10
  irq_set_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_done_i && !soft_rst_o && !ctrl_wr) |=> ist);

  // R11
  ien_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (we && addr == {1'b1, AL_SET} && !wdata[IEN_B]) |=> $stable(ien));
endmodule

bind ctlreg_bank ctlreg_bank_chk #(.IEN_B(IEN_B)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
  .fifo_empty_i(fifo_empty_i), .frame_done_i(frame_done_i),
  .soft_rst_o(soft_rst_o), .clk_gate_o(clk_gate_o), .run_o(run_o),
  .mode(mode_q), .ien(ien_q), .ist(ist_q));

// File: tb/ctlreg_bank_tb.sv
module ctlreg_bank_tb;
  localparam int RSTC  = 4;
  localparam int GATEC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        fifo_empty_i = 1'b1;
  logic        frame_done_i = 1'b0;
  logic [31:0] rdata;
  logic        soft_rst_o, clk_gate_o, run_o, fifo_flush_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ctlreg_bank #(.RST_CYCLES(RSTC), .GATE_CYCLES(GATEC)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .we(we),
    .fifo_empty_i(fifo_empty_i), .frame_done_i(frame_done_i),
    .rdata(rdata), .soft_rst_o(soft_rst_o), .clk_gate_o(clk_gate_o),
    .run_o(run_o), .fifo_flush_o(fifo_flush_o), .irq_o(irq_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; we = 1'b0;
    @(posedge clk);
    #1 v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, exp, p;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 soft_rst", 32'(soft_rst_o), 1);
    chk("R1 clk_gate", 32'(clk_gate_o), 1);
    chk("R1 run", 32'(run_o), 0);
    chk("R1 flush", 32'(fifo_flush_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    rd(3'd0, v); chk("R1 word0", v, 32'hC000_0000);
    rd(3'd4, v); chk("R1 word1", v, 32'h0);

    // R6 writes ignored while soft reset reads 1
    wr(3'd5, 32'h0000_0111);
    rd(3'd4, v); chk("R6 word1 held", v, 32'h0);
    chk("R6 flush held", 32'(fifo_flush_o), 0);
    wr(3'd1, 32'h0000_03FF);
    rd(3'd0, v); chk("R6 word0 held", v, 32'hC000_0000);
    chk("R6 run held", 32'(run_o), 0);
    wr(3'd2, 32'h4000_0000);
    repeat (GATEC + 2) @(negedge clk);
    chk("R6 gate kept", 32'(clk_gate_o), 1);

    // R4 soft reset release handshake
    wr(3'd2, 32'h8000_0000);
    for (int j = 0; j < RSTC; j++) begin
      chk("R4 still in reset", 32'(soft_rst_o), 1);
      @(negedge clk);
    end
    chk("R4 released", 32'(soft_rst_o), 0);
    chk("R7 gate still on", 32'(clk_gate_o), 1);
    rd(3'd0, v); chk("R4 poll word0", v, 32'h4000_0000);

    // R7 clock gate release handshake
    wr(3'd2, 32'h4000_0000);
    for (int j = 0; j < GATEC; j++) begin
      chk("R7 still gated", 32'(clk_gate_o), 1);
      @(negedge clk);
    end
    chk("R7 ungated", 32'(clk_gate_o), 0);
    wr(3'd2, 32'h8000_0000);
    rd(3'd0, v); chk("R4 second clear no-op", v, 32'h0);

    // R2 R3 R12 alias sweep on the configuration field
    exp = 32'h0;
    for (int al = 0; al < 4; al++) begin
      for (int i = 0; i < 8; i++) begin
        p = 32'((i * 37 + 5) << 2) & 32'h0000_03FC;
        wr({1'b0, 2'(al)}, p);
        case (al)
          0: exp = p;
          1: exp = exp | p;
          2: exp = exp & ~p;
          default: exp = exp;
        endcase
        rd(3'd0, v); chk("R12 R3 R2 word0 alias", v, exp);
      end
    end
    wr(3'd0, 32'h0);

    // R11 R2 alias sweep on the format field, enable kept
    wr(3'd4, 32'h0000_0100);
    exp = 32'h0000_0100;
    for (int al = 0; al < 4; al++) begin
      for (int f = 0; f < 16; f++) begin
        p = 32'(f << 4) | ((al == 0) ? 32'h100 : 32'h0);
        wr({1'b1, 2'(al)}, p);
        case (al)
          0: exp = p;
          1: exp = exp | p;
          2: exp = exp & ~p;
          default: exp = exp;
        endcase
        rd(3'd4, v); chk("R11 R2 word1 alias", v, exp);
      end
    end
    chk("R11 enable kept", v & 32'h100, 32'h100);
    chk("R10 no irq yet", 32'(irq_o), 0);

    // R9 flush control
    wr(3'd5, 32'h1);
    chk("R9 flush on", 32'(fifo_flush_o), 1);
    wr(3'd6, 32'h1);
    chk("R9 flush off", 32'(fifo_flush_o), 0);

    // R10 interrupt status
    wr(3'd5, 32'h100);
    @(negedge clk); frame_done_i = 1'b1;
    @(negedge clk); frame_done_i = 1'b0;
    chk("R10 irq raised", 32'(irq_o), 1);
    rd(3'd4, v); chk("R10 status bit", v & 32'h200, 32'h200);
    wr(3'd6, 32'h200);
    chk("R10 irq cleared", 32'(irq_o), 0);
    @(negedge clk);
    addr = 3'd6; wdata = 32'h200; we = 1'b1; frame_done_i = 1'b1;
    @(negedge clk);
    we = 1'b0; frame_done_i = 1'b0;
    chk("R10 pulse beats clear", 32'(irq_o), 1);
    wr(3'd6, 32'h100);
    chk("R10 enable gates irq", 32'(irq_o), 0);
    rd(3'd4, v); chk("R10 status held", v & 32'h300, 32'h200);
    wr(3'd6, 32'h200);

    // R8 graceful stop after drain
    fifo_empty_i = 1'b0;
    wr(3'd1, 32'h2);
    wr(3'd1, 32'h1);
    chk("R8 running", 32'(run_o), 1);
    wr(3'd2, 32'h2);
    for (int j = 0; j < 5; j++) begin
      chk("R8 draining", 32'(run_o), 1);
      @(negedge clk);
    end
    fifo_empty_i = 1'b1;
    @(negedge clk);
    chk("R8 stopped", 32'(run_o), 0);
    rd(3'd0, v); chk("R8 run bit reads 0", v & 32'h3, 32'h0);

    // R5 soft reset set returns fields to reset
    wr(3'd1, 32'h0000_03FC);
    wr(3'd5, 32'h0000_0101);
    wr(3'd1, 32'h8000_0000);
    chk("R5 soft_rst", 32'(soft_rst_o), 1);
    chk("R5 gate", 32'(clk_gate_o), 1);
    chk("R5 flush reset", 32'(fifo_flush_o), 0);
    rd(3'd0, v); chk("R5 word0", v, 32'hC000_0000);
    rd(3'd4, v); chk("R5 word1", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule